// File: doc/BRIEF.md
# Cache Preload Channel Sequencer

This block runs one preload channel that moves a run of 64-byte cache lines between external memory and a single way of a level-2 cache. Software sets a start address, a line count, a direction, a target way and interrupt options through a small register port, then starts the channel by writing the control register with its start bit set. The sequencer then works through the block one line at a time. It asks an external walker to translate the first line and every line that begins a new 4KB page. For each line it issues lookup, fill or evict commands to the cache. When the run ends it raises an interrupt.

For inbound runs a line is looked up first. A line that already sits in some other way stays where it is, and lines in non-cacheable pages are skipped. For outbound runs every line is looked up, and dirty lines are evicted. A translation fault ends the run early. In that case the start register receives the address that faulted, and the status register records the fault code. The walker, the cache arrays and the memory fabric sit outside the block and are reached through request/acknowledge ports.

Top module: `preload_chan`

## Requirements
- R1: After reset all four registers read zero, both request outputs are low and all three interrupt outputs are low.
- R2: The run starts at the start address with bits [5:0] forced to zero. Each line handled advances the address by 64, and exactly the programmed number of lines is handled.
- R3: A programmed count larger than WAY_LINES (default 256) is reduced to WAY_LINES. A count of zero sets the done flag without issuing any command.
- R4: A translation request is issued for the first line and for every later line whose address bits [11:0] are zero, and at no other time.
- R5: Inbound runs (control bit 4 = 1) send a lookup (ln_op 0) for each line. When the lookup reports no hit, a fill (ln_op 1) follows with ln_way equal to control bits [2:0]. When the lookup reports a hit in another way, no fill is sent.
- R6: In an inbound run, no line command is issued for any line of a page whose translation reports non-cacheable.
- R7: Outbound runs (control bit 4 = 0) send a lookup for each line. An evict (ln_op 2) follows only when the lookup reports the line dirty.
- R8: A translation fault stops the run and sets status bit 2. The fault code goes to status bits [11:8] and the faulting line address is written into the start register (select 0). The error interrupt is raised only when control bit 5 is set.
- R9: On normal completion status bit 1 is set. The completion interrupt appears on the secure output when control bit 29 is 1, and on the non-secure output when it is 0.
- R10: Status bit 0 reads 1 while the channel runs. Writes to the start (select 0), count (select 1) and control (select 2) registers are ignored during that time, including a write that has the start bit 31 set.
- R11: Interrupt outputs are levels. Each stays high until software writes one to the matching status bit (bit 1 for done, bit 2 for error) at select 3. Starting a run also clears both bits.
- R12: Only one command is outstanding on each port. A request stays high, with its address and operation unchanged, until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_sel | input | 2 | Write select: 0 start, 1 count, 2 control, 3 status (write-one-to-clear) |
| cfg_wr_data | input | 32 | Write data |
| cfg_rd_sel | input | 2 | Read select, same encoding |
| cfg_rd_data | output | 32 | Read data for the selected register |
| xl_req | output | 1 | Translation request |
| xl_addr | output | 32 | Line address to translate |
| xl_ack | input | 1 | Translation done |
| xl_fault | input | 1 | Translation faulted (valid with xl_ack) |
| xl_fault_code | input | 4 | Fault code (valid with xl_ack) |
| xl_cacheable | input | 1 | Page is cacheable (valid with xl_ack) |
| ln_req | output | 1 | Line command request |
| ln_op | output | 2 | 0 lookup, 1 fill, 2 evict |
| ln_addr | output | 32 | Line address |
| ln_way | output | 3 | Target way for fills |
| ln_ack | input | 1 | Line command done |
| ln_hit | input | 1 | Lookup found the line in another way |
| ln_dirty | input | 1 | Lookup found the line dirty |
| irq_done_sec | output | 1 | Completion interrupt, secure |
| irq_done_ns | output | 1 | Completion interrupt, non-secure |
| irq_error | output | 1 | Error interrupt |

## Verification
The bench targets runs that start in the last lines of a page. There a missed page check would skip the second translation, and an extra check would add a translation between lines. It also covers counts of zero and counts above one way. A missing clamp shows up as extra commands, and a zero count that is not special-cased lets the counter wrap into a huge run. Other cases are inbound pages that are non-cacheable or that hit in another way, where a careless design still sends fills. It also checks faults with the error enable on and off, where the start register must end up holding the faulting address, and register writes made while busy, which must not change the run or restart it.

// File: rtl/preload_pkg.sv
// Shared types and constants of the cache preload channel.
// Assumes 64-byte lines and 4KB pages; the register map fields are fixed here.
package preload_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_XLT,
        S_PRB,
        S_ACT,
        S_ADV
    } seq_st_t;

    localparam logic [1:0] OP_PROBE = 2'd0;
    localparam logic [1:0] OP_FILL  = 2'd1;
    localparam logic [1:0] OP_EVICT = 2'd2;

    localparam int LINE_BITS = 6;
    localparam int PAGE_BITS = 12;

    localparam logic [1:0] SEL_START = 2'd0;
    localparam logic [1:0] SEL_COUNT = 2'd1;
    localparam logic [1:0] SEL_CTRL  = 2'd2;
    localparam logic [1:0] SEL_STAT  = 2'd3;

    localparam int C_DIR = 4;
    localparam int C_EIE = 5;
    localparam int C_SEC = 29;
    localparam int C_GO  = 31;

    localparam int ST_BUSY = 0;
    localparam int ST_DONE = 1;
    localparam int ST_ERR  = 2;
endpackage

// File: rtl/preload_regs.sv
// Register file of the preload channel: start, count, control and status.
// Holds configuration stable while the channel runs, produces a one-cycle start
// pulse after an accepted start write, and turns status flags into level interrupts.
// Assumes the sequencer reports done and fault as single-cycle pulses.
module preload_regs
    import preload_pkg::*;
#(
    parameter int DW   = 32,
    parameter int FC_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [1:0]      wr_sel,
    input  logic [DW-1:0]   wr_data,
    input  logic [1:0]      rd_sel,
    output logic [DW-1:0]   rd_data,
    input  logic            seq_busy,
    input  logic            done_p,
    input  logic            fault_p,
    input  logic [DW-1:0]   fault_addr,
    input  logic [FC_W-1:0] fault_code,
    output logic [DW-1:0]   start_q,
    output logic [DW-1:0]   count_q,
    output logic [DW-1:0]   ctrl_q,
    output logic            go_q,
    output logic            busy_any,
    output logic            irq_sec,
    output logic            irq_ns,
    output logic            irq_err
);
    localparam int PAD_W = DW - 8 - FC_W;

    logic            accept_cfg;
    logic            start_wr;
    logic            stat_wr;
    logic            done_q;
    logic            err_q;
    logic [FC_W-1:0] fcode_q;

    assign busy_any   = seq_busy | go_q;
    assign accept_cfg = wr_en && !busy_any;
    assign start_wr   = accept_cfg && (wr_sel == SEL_CTRL) && wr_data[C_GO];
    assign stat_wr    = wr_en && (wr_sel == SEL_STAT);

    // Configuration registers, frozen while busy; a fault rewrites the start address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= '0;
            count_q <= '0;
            ctrl_q  <= '0;
            go_q    <= 1'b0;
        end else begin
            go_q <= start_wr;
            if (accept_cfg) begin
                case (wr_sel)
                    SEL_START: start_q <= wr_data;
                    SEL_COUNT: count_q <= wr_data;
                    SEL_CTRL:  ctrl_q  <= wr_data & ~(DW'(1) << C_GO);
                    default: ;
                endcase
            end
            if (fault_p) start_q <= fault_addr;
        end
    end

    // Status flags: set by the sequencer, cleared by write-one or by a new start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q  <= 1'b0;
            err_q   <= 1'b0;
            fcode_q <= '0;
        end else begin
            if (stat_wr && wr_data[ST_DONE]) done_q <= 1'b0;
            if (stat_wr && wr_data[ST_ERR])  err_q  <= 1'b0;
            if (start_wr) begin
                done_q <= 1'b0;
                err_q  <= 1'b0;
            end
            if (done_p) done_q <= 1'b1;
            if (fault_p) begin
                err_q   <= 1'b1;
                fcode_q <= fault_code;
            end
        end
    end

    // Level interrupts routed by the control register.
    always_comb begin
        irq_sec = done_q & ctrl_q[C_SEC];
        irq_ns  = done_q & ~ctrl_q[C_SEC];
        irq_err = err_q & ctrl_q[C_EIE];
    end

    // Read-back multiplexer.
    always_comb begin
        case (rd_sel)
            SEL_START: rd_data = start_q;
            SEL_COUNT: rd_data = count_q;
            SEL_CTRL:  rd_data = ctrl_q;
            default:   rd_data = {{PAD_W{1'b0}}, fcode_q, 5'b0, err_q, done_q, busy_any};
        endcase
    end

    a_r10_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        busy_any |=> $stable(count_q) && $stable(ctrl_q));
    a_r10_start_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        busy_any && !fault_p |=> $stable(start_q));
    a_r8_start_capture: assert property (@(posedge clk) disable iff (!rst_n)
        fault_p |=> start_q == $past(fault_addr));
    a_r8_err_from_fault: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_q) |-> $past(fault_p));
    a_r9_done_from_seq: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_q) |-> $past(done_p));
    a_r11_done_level: assert property (@(posedge clk) disable iff (!rst_n)
        done_q && !(stat_wr && wr_data[ST_DONE]) && !start_wr |=> done_q);
endmodule

// File: rtl/preload_walk.sv
// Line-by-line sequencer of the preload channel.
// Translates at the first line and at each page start, then looks up each line and
// fills or evicts it depending on direction and lookup result. Each request is held
// until its acknowledge, so at most one command is outstanding per port.
// Assumes response fields are valid in the cycle of the acknowledge.
module preload_walk
    import preload_pkg::*;
#(
    parameter int AW        = 32,
    parameter int WAY_LINES = 256,
    parameter int WAY_W     = 3,
    parameter int FC_W      = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 go,
    input  logic [AW-1:LINE_BITS] start_line,
    input  logic [AW-1:0]        line_cnt,
    input  logic                 inbound,
    input  logic [WAY_W-1:0]     way,
    output logic                 tr_req,
    output logic [AW-1:0]        tr_va,
    input  logic                 tr_ack,
    input  logic                 tr_fault,
    input  logic [FC_W-1:0]      tr_fcode,
    input  logic                 tr_cacheable,
    output logic                 ln_req,
    output logic [1:0]           ln_op,
    output logic [AW-1:0]        ln_addr,
    output logic [WAY_W-1:0]     ln_way,
    input  logic                 ln_ack,
    input  logic                 ln_hit,
    input  logic                 ln_dirty,
    output logic                 busy,
    output logic                 done_p,
    output logic                 fault_p,
    output logic [AW-1:0]        fault_addr,
    output logic [FC_W-1:0]      fault_code
);
    localparam int RW = $clog2(WAY_LINES + 1);
    localparam logic [AW-1:0] LINE_STEP = AW'(1) << LINE_BITS;

    seq_st_t          st;
    logic [AW-1:0]    cur;
    logic [AW-1:0]    nxt;
    logic [RW-1:0]    rem;
    logic [RW-1:0]    clamped;
    logic             dir_q;
    logic             cach_q;
    logic [WAY_W-1:0] way_q;

    // Length limit: never more lines than one way holds.
    always_comb begin
        clamped = (line_cnt > AW'(WAY_LINES)) ? RW'(WAY_LINES) : RW'(line_cnt);
        nxt     = cur + LINE_STEP;
    end

    // Main state machine with address and line counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= S_IDLE;
            cur        <= '0;
            rem        <= '0;
            dir_q      <= 1'b0;
            cach_q     <= 1'b0;
            way_q      <= '0;
            done_p     <= 1'b0;
            fault_p    <= 1'b0;
            fault_code <= '0;
        end else begin
            done_p  <= 1'b0;
            fault_p <= 1'b0;
            case (st)
                S_IDLE: if (go) begin
                    cur   <= {start_line, {LINE_BITS{1'b0}}};
                    rem   <= clamped;
                    dir_q <= inbound;
                    way_q <= way;
                    if (clamped == '0) done_p <= 1'b1;
                    else               st     <= S_XLT;
                end
                S_XLT: if (tr_ack) begin
                    if (tr_fault) begin
                        fault_p    <= 1'b1;
                        fault_code <= tr_fcode;
                        st         <= S_IDLE;
                    end else begin
                        cach_q <= tr_cacheable;
                        st     <= (dir_q && !tr_cacheable) ? S_ADV : S_PRB;
                    end
                end
                S_PRB: if (ln_ack) begin
                    if (dir_q) st <= ln_hit   ? S_ADV : S_ACT;
                    else       st <= ln_dirty ? S_ACT : S_ADV;
                end
                S_ACT: if (ln_ack) st <= S_ADV;
                S_ADV: begin
                    rem <= rem - RW'(1);
                    cur <= nxt;
                    if (rem == RW'(1)) begin
                        done_p <= 1'b1;
                        st     <= S_IDLE;
                    end else if (nxt[PAGE_BITS-1:0] == '0) begin
                        st <= S_XLT;
                    end else if (dir_q && !cach_q) begin
                        st <= S_ADV;
                    end else begin
                        st <= S_PRB;
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    // Port outputs decoded from the state.
    always_comb begin
        busy       = (st != S_IDLE);
        tr_req     = (st == S_XLT);
        tr_va      = cur;
        ln_req     = (st == S_PRB) || (st == S_ACT);
        ln_addr    = cur;
        ln_way     = way_q;
        ln_op      = (st == S_PRB) ? OP_PROBE : (dir_q ? OP_FILL : OP_EVICT);
        fault_addr = cur;
    end

    a_r12_ln_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ln_req && !ln_ack |=> ln_req && $stable(ln_addr) && $stable(ln_op));
    a_r12_tr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        tr_req && !tr_ack |=> tr_req && $stable(tr_va));
    a_r2_line_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        ln_req |-> ln_addr[LINE_BITS-1:0] == '0);
    a_r4_page_xlate: assert property (@(posedge clk) disable iff (!rst_n)
        tr_req && !$past(tr_req) && $past(busy) |-> tr_va[PAGE_BITS-1:0] == '0);
    a_r6_nc_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ln_req |-> !(dir_q && !cach_q));
    a_r3_clamp: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> rem <= RW'(WAY_LINES));
endmodule

// File: rtl/preload_chan.sv
// Top of the single cache preload channel: register file plus line sequencer.
// Assumes one clock domain and external walker/cache ports that hold their
// response fields valid with the acknowledge.
module preload_chan
    import preload_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int WAY_LINES = 256,
    parameter int WAY_W     = 3,
    parameter int FC_W      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [1:0]        cfg_wr_sel,
    input  logic [ADDR_W-1:0] cfg_wr_data,
    input  logic [1:0]        cfg_rd_sel,
    output logic [ADDR_W-1:0] cfg_rd_data,
    output logic              xl_req,
    output logic [ADDR_W-1:0] xl_addr,
    input  logic              xl_ack,
    input  logic              xl_fault,
    input  logic [FC_W-1:0]   xl_fault_code,
    input  logic              xl_cacheable,
    output logic              ln_req,
    output logic [1:0]        ln_op,
    output logic [ADDR_W-1:0] ln_addr,
    output logic [WAY_W-1:0]  ln_way,
    input  logic              ln_ack,
    input  logic              ln_hit,
    input  logic              ln_dirty,
    output logic              irq_done_sec,
    output logic              irq_done_ns,
    output logic              irq_error
);
    logic [ADDR_W-1:0] start_q, count_q, ctrl_q, fault_addr;
    logic [FC_W-1:0]   fault_code;
    logic              go_q, busy_any, seq_busy, done_p, fault_p;

    preload_regs #(.DW(ADDR_W), .FC_W(FC_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (cfg_wr_en),
        .wr_sel     (cfg_wr_sel),
        .wr_data    (cfg_wr_data),
        .rd_sel     (cfg_rd_sel),
        .rd_data    (cfg_rd_data),
        .seq_busy   (seq_busy),
        .done_p     (done_p),
        .fault_p    (fault_p),
        .fault_addr (fault_addr),
        .fault_code (fault_code),
        .start_q    (start_q),
        .count_q    (count_q),
        .ctrl_q     (ctrl_q),
        .go_q       (go_q),
        .busy_any   (busy_any),
        .irq_sec    (irq_done_sec),
        .irq_ns     (irq_done_ns),
        .irq_err    (irq_error)
    );

    preload_walk #(.AW(ADDR_W), .WAY_LINES(WAY_LINES), .WAY_W(WAY_W), .FC_W(FC_W)) u_walk (
        .clk          (clk),
        .rst_n        (rst_n),
        .go           (go_q),
        .start_line   (start_q[ADDR_W-1:LINE_BITS]),
        .line_cnt     (count_q),
        .inbound      (ctrl_q[C_DIR]),
        .way          (ctrl_q[WAY_W-1:0]),
        .tr_req       (xl_req),
        .tr_va        (xl_addr),
        .tr_ack       (xl_ack),
        .tr_fault     (xl_fault),
        .tr_fcode     (xl_fault_code),
        .tr_cacheable (xl_cacheable),
        .ln_req       (ln_req),
        .ln_op        (ln_op),
        .ln_addr      (ln_addr),
        .ln_way       (ln_way),
        .ln_ack       (ln_ack),
        .ln_hit       (ln_hit),
        .ln_dirty     (ln_dirty),
        .busy         (seq_busy),
        .done_p       (done_p),
        .fault_p      (fault_p),
        .fault_addr   (fault_addr),
        .fault_code   (fault_code)
    );

    a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_any |-> !xl_req && !ln_req);
endmodule

// File: tb/preload_chan_bench.sv
// Bench: behavioural model builds the expected command queue per run and every
// clock the responder compares each acknowledged command against it.
module preload_chan_bench;
    localparam int WL = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [1:0]  cfg_wr_sel = 2'd0;
    logic [31:0] cfg_wr_data = 32'd0;
    logic [1:0]  cfg_rd_sel = 2'd0;
    logic [31:0] cfg_rd_data;
    logic        xl_req;
    logic [31:0] xl_addr;
    logic        xl_ack = 1'b0;
    logic        xl_fault, xl_cacheable;
    logic [3:0]  xl_fault_code;
    logic        ln_req;
    logic [1:0]  ln_op;
    logic [31:0] ln_addr;
    logic [2:0]  ln_way;
    logic        ln_ack = 1'b0;
    logic        ln_hit, ln_dirty;
    logic        irq_done_sec, irq_done_ns, irq_error;

    int checks = 0;
    int errors = 0;
    logic [19:0] fault_pg = 20'hFFFFF;
    logic [2:0]  nc_pg = 3'd4;
    int          dly = 0;
    logic [2:0]  exp_way = 3'd0;
    logic        exp_fault = 1'b0;
    logic [31:0] exp_faddr = 32'd0;
    logic [33:0] expq[$];

    always #4 clk = ~clk;

    preload_chan u_preload_chan (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_sel(cfg_wr_sel), .cfg_wr_data(cfg_wr_data),
        .cfg_rd_sel(cfg_rd_sel), .cfg_rd_data(cfg_rd_data),
        .xl_req(xl_req), .xl_addr(xl_addr), .xl_ack(xl_ack), .xl_fault(xl_fault),
        .xl_fault_code(xl_fault_code), .xl_cacheable(xl_cacheable),
        .ln_req(ln_req), .ln_op(ln_op), .ln_addr(ln_addr), .ln_way(ln_way),
        .ln_ack(ln_ack), .ln_hit(ln_hit), .ln_dirty(ln_dirty),
        .irq_done_sec(irq_done_sec), .irq_done_ns(irq_done_ns), .irq_error(irq_error)
    );

    function automatic logic f_fault(input logic [31:0] a);
        return a[31:12] == fault_pg;
    endfunction
    function automatic logic f_cach(input logic [31:0] a);
        return {1'b0, a[13:12]} != nc_pg;
    endfunction
    function automatic logic f_hit(input logic [31:0] a);
        return a[8:6] == 3'd1;
    endfunction
    function automatic logic f_dirty(input logic [31:0] a);
        return a[7:6] == 2'd2;
    endfunction

    assign xl_fault      = xl_req & f_fault(xl_addr);
    assign xl_cacheable  = f_cach(xl_addr);
    assign xl_fault_code = 4'h5;
    assign ln_hit        = f_hit(ln_addr);
    assign ln_dirty      = f_dirty(ln_addr);

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Compare one acknowledged command (kind 0 translate, 1 lookup, 2 fill, 3 evict).
    task automatic see(input logic [1:0] kind, input logic [31:0] a, input logic [2:0] w);
        logic [33:0] e;
        if (expq.size() == 0) begin
            chk(1'b0, "R2 R3 R6 unexpected command", {30'd0, kind, a}, 64'd0);
            return;
        end
        e = expq.pop_front();
        chk({kind, a} == e, "R2 R4 R5 R7 command order", {30'd0, kind, a}, {30'd0, e});
        if (kind == 2'd2) chk(w == exp_way, "R5 fill way", {61'd0, w}, {61'd0, exp_way});
    endtask

    // Responder for both ports, compares every clock.
    initial begin : responder
        int tc = 0;
        int lc = 0;
        logic [31:0] ta = 32'd0;
        logic [31:0] la = 32'd0;
        forever begin
            @(negedge clk);
            if (xl_ack) begin
                xl_ack = 1'b0;
                tc = 0;
            end else if (xl_req) begin
                if (tc == 0) ta = xl_addr;
                if (tc >= dly) begin
                    chk(xl_addr == ta, "R12 translate address held", {32'd0, xl_addr}, {32'd0, ta});
                    see(2'd0, xl_addr, 3'd0);
                    xl_ack = 1'b1;
                end else tc++;
            end
            if (ln_ack) begin
                ln_ack = 1'b0;
                lc = 0;
            end else if (ln_req) begin
                if (lc == 0) la = ln_addr;
                if (lc >= dly) begin
                    chk(ln_addr == la, "R12 line address held", {32'd0, ln_addr}, {32'd0, la});
                    see(ln_op + 2'd1, ln_addr, ln_way);
                    ln_ack = 1'b1;
                end else lc++;
            end
        end
    end

    task automatic wr(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1;
        cfg_wr_sel = sel;
        cfg_wr_data = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [31:0] v);
        cfg_rd_sel = sel;
        #1;
        v = cfg_rd_data;
    endtask

    task automatic wait_end();
        logic [31:0] s;
        int t = 0;
        do begin
            @(negedge clk);
            rd(2'd3, s);
            t++;
        end while (!s[1] && !s[2] && t < 20000);
        chk(t < 20000, "R2 run ended", t, 20000);
        repeat (2) @(negedge clk);
        chk(expq.size() == 0, "R2 all expected commands seen", expq.size(), 0);
    endtask

    // Build expected commands, start the run, optionally poke registers while busy.
    task automatic run(input logic [31:0] start, input logic [31:0] cnt, input logic [31:0] ctl,
                       input int d, input bit poke);
        logic [31:0] a;
        logic [31:0] s;
        logic cach = 1'b1;
        int n;
        dly = d;
        exp_way = ctl[2:0];
        exp_fault = 1'b0;
        wr(2'd0, start);
        wr(2'd1, cnt);
        a = {start[31:6], 6'd0};
        n = (cnt > WL) ? WL : int'(cnt);
        for (int i = 0; i < n; i++) begin
            if (i == 0 || a[11:0] == 12'd0) begin
                expq.push_back({2'd0, a});
                if (f_fault(a)) begin
                    exp_fault = 1'b1;
                    exp_faddr = a;
                    break;
                end
                cach = f_cach(a);
            end
            if (ctl[4]) begin
                if (cach) begin
                    expq.push_back({2'd1, a});
                    if (!f_hit(a)) expq.push_back({2'd2, a});
                end
            end else begin
                expq.push_back({2'd1, a});
                if (f_dirty(a)) expq.push_back({2'd3, a});
            end
            a = a + 32'd64;
        end
        wr(2'd2, ctl | 32'h8000_0000);
        if (poke) begin
            repeat (2) @(negedge clk);
            rd(2'd3, s);
            chk(s[0] == 1'b1, "R10 busy bit while running", {63'd0, s[0]}, 64'd1);
            wr(2'd0, 32'hDEAD_0000);
            wr(2'd1, 32'd3);
            wr(2'd2, 32'h8000_0017);
        end
        wait_end();
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R2 watchdog expired actual=hung expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        for (int s = 0; s < 4; s++) begin
            rd(2'(s), v);
            chk(v == 32'd0, "R1 register reset value", v, 0);
        end
        chk({irq_done_sec, irq_done_ns, irq_error, xl_req, ln_req} == 5'd0, "R1 outputs idle",
            {irq_done_sec, irq_done_ns, irq_error, xl_req, ln_req}, 0);

        // Inbound across a page, hits skip fill, secure completion (R2 R4 R5 R9)
        run(32'h0000_1F90, 32'd5, 32'h2000_0015, 1, 1'b0);
        rd(2'd3, v);
        chk(v[1] && !v[0], "R9 done set and idle", v, 32'h2);
        chk(irq_done_sec && !irq_done_ns, "R9 secure route", {irq_done_sec, irq_done_ns}, 2'b10);
        rd(2'd0, v);
        chk(v == 32'h0000_1F90, "R2 start register kept", v, 32'h1F90);
        repeat (5) @(negedge clk);
        chk(irq_done_sec, "R11 level held", irq_done_sec, 1);
        wr(2'd3, 32'h2);
        @(negedge clk);
        chk(!irq_done_sec && !irq_done_ns, "R11 cleared by write-one", irq_done_sec, 0);

        // Inbound into a non-cacheable page, non-secure route (R6 R9)
        nc_pg = 3'd1;
        run(32'h0000_0F80, 32'd6, 32'h0000_0012, 0, 1'b0);
        chk(irq_done_ns && !irq_done_sec, "R9 non-secure route", {irq_done_sec, irq_done_ns}, 2'b01);
        wr(2'd3, 32'h2);
        nc_pg = 3'd4;

        // Outbound with evicts, writes while busy ignored (R7 R10)
        run(32'h0000_4000, 32'd8, 32'h0000_0000, 2, 1'b1);
        rd(2'd0, v);
        chk(v == 32'h0000_4000, "R10 start write ignored while busy", v, 32'h4000);
        rd(2'd1, v);
        chk(v == 32'd8, "R10 count write ignored while busy", v, 8);
        rd(2'd2, v);
        chk(v == 32'd0, "R10 control write ignored while busy", v, 0);
        wr(2'd3, 32'h2);

        // Count above one way, then zero count (R3)
        run(32'h0000_0000, 32'd300, 32'h0000_0000, 0, 1'b0);
        wr(2'd3, 32'h2);
        run(32'h0000_0100, 32'd0, 32'h0000_0000, 0, 1'b0);
        rd(2'd3, v);
        chk(v[1] == 1'b1, "R3 zero count completes", v, 32'h2);
        wr(2'd3, 32'h2);

        // Fault with error interrupt enabled (R8 R11)
        fault_pg = 20'h00003;
        run(32'h0000_2F00, 32'd10, 32'h0000_0020, 1, 1'b0);
        rd(2'd3, v);
        chk(v[2] && !v[1], "R8 error flag without done", v, 32'h504);
        chk(v[11:8] == 4'h5, "R8 fault code", v[11:8], 5);
        rd(2'd0, v);
        chk(v == exp_faddr && exp_fault, "R8 faulting address in start", v, exp_faddr);
        chk(irq_error, "R8 error interrupt enabled", irq_error, 1);
        wr(2'd3, 32'h4);
        @(negedge clk);
        chk(!irq_error, "R11 error cleared by write-one", irq_error, 0);

        // Fault with error interrupt disabled, inbound (R8)
        fault_pg = 20'h00010;
        run(32'h0000_FF40, 32'd8, 32'h0000_0013, 0, 1'b0);
        rd(2'd3, v);
        chk(v[2] == 1'b1, "R8 error flag set", v, 32'h504);
        chk(!irq_error, "R8 error interrupt masked", irq_error, 0);
        rd(2'd0, v);
        chk(v == 32'h0001_0000, "R8 faulting address in start", v, 32'h10000);
        wr(2'd3, 32'h4);
        fault_pg = 20'hFFFFF;

        repeat (4) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule